// File: doc/BRIEF.md
# Interrupt Request Priority Tracker

This block keeps the interrupt bookkeeping for one local interrupt controller. It covers 256 vectors. Three bit vectors track each vector's state: pending (requested but not yet taken), in-service (taken by the core and not yet retired), and level-triggered. Each bit vector is stored as eight 32-bit words. Vector v sits in word v/32 at bit v%32. A vector's priority class is its upper nibble, v[7:4], so each class holds 16 vectors.

The block also holds a task-priority value written by software. From that value and the highest in-service vector it forms the processor priority, which is always readable. It offers the highest deliverable pending vector to the core through a valid/ready stream, and the core acknowledges by taking the offer. An end-of-interrupt strobe retires the highest in-service vector. When the retired vector was level-triggered, the block emits a one-cycle broadcast pulse that carries the vector.

Back-pressure rules:
- On the accept stream, a request is taken in a cycle where both `acc_valid` and `acc_ready` are high. `acc_ready` simply follows the global enable, so an upstream source holds its request while the block is disabled.
- On the offer stream, the core may hold `offer_ready` for as long as it likes. The offer itself may be withdrawn without a handshake: when priority rises, and for one cycle after any take or task-priority write.

Top module: `irq_prio_tracker`

## Requirements
- R1: An accept fires when `acc_valid` and `acc_ready` are both high. When it succeeds, `acc_ok` is high in that same cycle and the vector's pending bit is set at that clock edge. An edge-triggered accept of a vector that is already pending still reports `acc_ok`=1.
- R2: A level-triggered accept (`acc_level`=1) of a vector whose pending bit is already set is refused: `acc_ok`=0 and no state changes. Any other successful level-triggered accept also sets the vector's level bit.
- R3: `ppr_o` equals the task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise `ppr_o` equals that vector with bits 3:0 cleared. An empty in-service set counts as vector 0.
- R4: A task-priority write (`tpr_we`) stores only bits 7:0 of `tpr_wdata`. All other bits are dropped.
- R5: At each clock edge, the highest pending vector is registered as the offer when its class value (vector & 0xF0) is strictly greater than `ppr_o`. It is shown on `offer_valid`/`offer_vec` from the following cycle. With no pending vector, nothing is offered.
- R6: Vectors 0 to 15 are never offered. They are never counted as the highest in-service vector, even when their pending bits are set.
- R7: A take (`offer_valid` and `offer_ready` both high) sets the in-service bit of `offer_vec` and clears its pending bit at the same edge. If an accept names the same vector in that same cycle, the pending bit stays set.
- R8: An `eoi_we` strobe clears the highest in-service bit. If that vector's level bit was set, the level bit is also cleared and `eoi_bc_valid` pulses for one cycle, in the cycle after the strobe, with `eoi_bc_vec` set to the vector. An `eoi_we` strobe with an empty in-service set changes nothing.
- R9: While `en_i` is low, `acc_ready` and `offer_valid` are low. All stored bits and the task priority are kept, and the offer returns once `en_i` is high again.
- R10: In the cycle after a take or a task-priority write, `offer_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Global enable |
| acc_valid | input | 1 | Accept request valid |
| acc_ready | output | 1 | Accept request can be taken |
| acc_vec | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_ok | output | 1 | Accept taken and recorded (same cycle) |
| offer_valid | output | 1 | A deliverable vector is offered |
| offer_ready | input | 1 | Core takes the offered vector |
| offer_vec | output | 8 | Offered vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_bc_valid | output | 1 | Level-triggered retirement pulse |
| eoi_bc_vec | output | 8 | Vector retired by that pulse |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data |
| ppr_o | output | 8 | Processor priority |

## Verification
The bench builds the block with its default parameters:
- 256 vectors in 32-bit words, with 16-vector classes and the lowest class reserved.
- Random vectors therefore reach every word of all three bit vectors.
- They also reach the reserved class and the boundary where a pending class equals the processor priority.

Directed sequences cover:
- a take and an accept of the same vector in one cycle;
- a refused duplicate level request;
- retirement with and without a broadcast, and retirement on an empty in-service set;
- disabling the block with requests pending.

// File: rtl/irqtrk_pkg.sv
package irqtrk_pkg;
  parameter int unsigned IT_NUM_VEC    = 256;
  parameter int unsigned IT_WORD_W     = 32;
  parameter int unsigned IT_CLASS_SIZE = 16;
  parameter int unsigned IT_RSVD_VEC   = 16;
  parameter int unsigned IT_DATA_W     = 32;
endpackage

// File: rtl/irqtrk_bitmap.sv
module irqtrk_bitmap #(
  parameter int unsigned NUM_VEC = irqtrk_pkg::IT_NUM_VEC,
  parameter int unsigned WORD_W  = irqtrk_pkg::IT_WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [$clog2(NUM_VEC)-1:0] set_idx,
  input  logic                       clr_en,
  input  logic [$clog2(NUM_VEC)-1:0] clr_idx,
  output logic [NUM_VEC-1:0]         bits_o
);
  localparam int unsigned VEC_W  = $clog2(NUM_VEC);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned WSEL_W = VEC_W - BIT_W;
  localparam int unsigned NWORDS = NUM_VEC / WORD_W;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              set_hit;
    logic              clr_hit;

    assign set_hit = set_en && (set_idx[VEC_W-1:BIT_W] == WSEL_W'(w));
    assign clr_hit = clr_en && (clr_idx[VEC_W-1:BIT_W] == WSEL_W'(w));

    // clear first, set last: a set in the same cycle wins
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        if (clr_hit) word_q[clr_idx[BIT_W-1:0]] <= 1'b0;
        if (set_hit) word_q[set_idx[BIT_W-1:0]] <= 1'b1;
      end
    end

    assign bits_o[w*WORD_W +: WORD_W] = word_q;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_o[$past(set_idx)]); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !bits_o[$past(clr_idx)]); // R8
endmodule

// File: rtl/irqtrk_prio_enc.sv
module irqtrk_prio_enc #(
  parameter int unsigned NUM_VEC = irqtrk_pkg::IT_NUM_VEC,
  parameter int unsigned WORD_W  = irqtrk_pkg::IT_WORD_W,
  parameter int unsigned RSVD    = irqtrk_pkg::IT_RSVD_VEC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_VEC-1:0]         bits_i,
  output logic                       hit_o,
  output logic [$clog2(NUM_VEC)-1:0] idx_o
);
  localparam int unsigned VEC_W  = $clog2(NUM_VEC);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned WSEL_W = VEC_W - BIT_W;
  localparam int unsigned NWORDS = NUM_VEC / WORD_W;

  logic [NWORDS-1:0] w_any;
  logic [BIT_W-1:0]  w_loc [NWORDS];

  // per-word search, reserved vectors masked out
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic             any_l;
    logic [BIT_W-1:0] loc_l;

    always_comb begin
      any_l = 1'b0;
      loc_l = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits_i[w*WORD_W + b] && ((w*WORD_W + b) >= RSVD)) begin
          any_l = 1'b1;
          loc_l = BIT_W'(b);
        end
      end
    end

    assign w_any[w] = any_l;
    assign w_loc[w] = loc_l;
  end

  // word-level pick: highest word with a hit
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (w_any[w]) begin
        hit_o = 1'b1;
        idx_o = {WSEL_W'(w), w_loc[w]};
      end
    end
  end

  AST_ENC_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((bits_i >> idx_o) == NUM_VEC'(1))); // R5

  AST_ENC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (idx_o >= VEC_W'(RSVD))); // R6

  AST_ENC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> ((bits_i >> RSVD) == '0)); // R6
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker #(
  parameter int unsigned NUM_VEC    = irqtrk_pkg::IT_NUM_VEC,
  parameter int unsigned WORD_W     = irqtrk_pkg::IT_WORD_W,
  parameter int unsigned CLASS_SIZE = irqtrk_pkg::IT_CLASS_SIZE,
  parameter int unsigned RSVD       = irqtrk_pkg::IT_RSVD_VEC,
  parameter int unsigned DATA_W     = irqtrk_pkg::IT_DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic                       acc_valid,
  output logic                       acc_ready,
  input  logic [$clog2(NUM_VEC)-1:0] acc_vec,
  input  logic                       acc_level,
  output logic                       acc_ok,
  output logic                       offer_valid,
  input  logic                       offer_ready,
  output logic [$clog2(NUM_VEC)-1:0] offer_vec,
  input  logic                       eoi_we,
  output logic                       eoi_bc_valid,
  output logic [$clog2(NUM_VEC)-1:0] eoi_bc_vec,
  input  logic                       tpr_we,
  input  logic [DATA_W-1:0]          tpr_wdata,
  output logic [$clog2(NUM_VEC)-1:0] ppr_o
);
  localparam int unsigned VEC_W   = $clog2(NUM_VEC);
  localparam int unsigned CLS_LSB = $clog2(CLASS_SIZE);

  logic [NUM_VEC-1:0] irr_bits, isr_bits, tmr_bits;
  logic               irr_hit, isr_hit;
  logic [VEC_W-1:0]   irr_idx, isr_idx, isr_top;
  logic [VEC_W-1:0]   tpr_q, cand_cls;
  logic               acc_fire, take, eoi_do, eoi_lvl, cand;
  logic               offv_q, bc_q;
  logic [VEC_W-1:0]   offvec_q, bcvec_q;
  logic               unused_tpr_hi;

  assign unused_tpr_hi = ^tpr_wdata[DATA_W-1:VEC_W];

  // accept stream
  assign acc_ready = en_i;
  assign acc_fire  = acc_valid && en_i;
  assign acc_ok    = acc_fire && !(acc_level && irr_bits[acc_vec]);

  // take and end-of-interrupt
  assign take    = offer_valid && offer_ready;
  assign eoi_do  = eoi_we && isr_hit;
  assign eoi_lvl = eoi_do && tmr_bits[isr_idx];

  irqtrk_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(acc_ok), .set_idx(acc_vec),
    .clr_en(take), .clr_idx(offer_vec),
    .bits_o(irr_bits));

  irqtrk_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(take), .set_idx(offer_vec),
    .clr_en(eoi_do), .clr_idx(isr_idx),
    .bits_o(isr_bits));

  irqtrk_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .set_en(acc_ok && acc_level), .set_idx(acc_vec),
    .clr_en(eoi_lvl), .clr_idx(isr_idx),
    .bits_o(tmr_bits));

  irqtrk_prio_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .RSVD(RSVD)) u_irr_enc (
    .clk(clk), .rst_n(rst_n), .bits_i(irr_bits),
    .hit_o(irr_hit), .idx_o(irr_idx));

  irqtrk_prio_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .RSVD(RSVD)) u_isr_enc (
    .clk(clk), .rst_n(rst_n), .bits_i(isr_bits),
    .hit_o(isr_hit), .idx_o(isr_idx));

  // processor priority
  assign isr_top = isr_hit ? isr_idx : '0;
  always_comb begin
    if (tpr_q[VEC_W-1:CLS_LSB] >= isr_top[VEC_W-1:CLS_LSB])
      ppr_o = tpr_q;
    else
      ppr_o = {isr_top[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
  end

  assign cand_cls = {irr_idx[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
  assign cand     = irr_hit && (cand_cls > ppr_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q    <= '0;
      offv_q   <= 1'b0;
      offvec_q <= '0;
      bc_q     <= 1'b0;
      bcvec_q  <= '0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
      offv_q   <= cand && en_i && !take && !tpr_we;
      offvec_q <= irr_idx;
      bc_q     <= eoi_lvl;
      bcvec_q  <= isr_idx;
    end
  end

  assign offer_valid  = offv_q && en_i;
  assign offer_vec    = offvec_q;
  assign eoi_bc_valid = bc_q;
  assign eoi_bc_vec   = bcvec_q;

  AST_OFFER_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> ({offer_vec[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}} > $past(ppr_o))); // R5

  AST_TAKE_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !offer_valid); // R10

  AST_TPR_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> !offer_valid); // R10

  AST_BC_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bc_valid |-> $past(eoi_we)); // R8

  AST_NO_OFFER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |-> !offer_valid); // R9
endmodule

// File: tb/test_irq_prio_tracker.sv
module test_irq_prio_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic       clk = 1'b0;
  logic       rst_n, en_i, acc_valid, acc_level, offer_ready, eoi_we, tpr_we;
  logic [7:0] acc_vec;
  logic [31:0] tpr_wdata;
  logic       acc_ready, acc_ok, offer_valid, eoi_bc_valid;
  logic [7:0] offer_vec, eoi_bc_vec, ppr_o;

  int total = 0;
  int bad = 0;

  // reference state
  bit [NV-1:0] m_irr, m_isr, m_tmr;
  int m_tpr, m_offvec, m_bcvec;
  bit m_offv, m_bcv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_tracker i_irq_prio_tracker (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_vec(acc_vec),
    .acc_level(acc_level), .acc_ok(acc_ok),
    .offer_valid(offer_valid), .offer_ready(offer_ready), .offer_vec(offer_vec),
    .eoi_we(eoi_we), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr_o(ppr_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int top_vec(input bit [NV-1:0] a);
    for (int i = NV-1; i >= 16; i--) if (a[i]) return i;
    return -1;
  endfunction

  // compare this cycle, then advance the model across one clock edge
  task automatic tick();
    int hir, his, isrv, ppr;
    bit e_ov, ok, tk, cand, lvl_hit;
    #1;
    hir  = top_vec(m_irr);
    his  = top_vec(m_isr);
    isrv = (his < 0) ? 0 : his;
    ppr  = ((m_tpr >> 4) >= (isrv >> 4)) ? m_tpr : (isrv & 'hF0);
    e_ov = m_offv && en_i;
    ok   = acc_valid && en_i && !(acc_level && m_irr[acc_vec]);
    tk   = offer_ready && e_ov;
    chk(acc_ready == en_i, "R9 acc_ready", acc_ready, en_i);
    chk(acc_ok == ok, "R2 acc_ok", acc_ok, ok);
    chk(ppr_o == ppr[7:0], "R3 ppr", ppr_o, ppr);
    chk(offer_valid == e_ov, "R5 offer_valid", offer_valid, e_ov);
    if (e_ov) chk(offer_vec == m_offvec[7:0], "R5 offer_vec", offer_vec, m_offvec);
    chk(eoi_bc_valid == m_bcv, "R8 eoi_bc_valid", eoi_bc_valid, m_bcv);
    if (m_bcv) chk(eoi_bc_vec == m_bcvec[7:0], "R8 eoi_bc_vec", eoi_bc_vec, m_bcvec);
    cand = (hir >= 0) && ((hir & 'hF0) > ppr);
    m_bcv = 1'b0;
    if (eoi_we && his >= 0) begin
      lvl_hit = m_tmr[his];
      m_isr[his] = 1'b0;
      if (lvl_hit) begin
        m_tmr[his] = 1'b0;
        m_bcv = 1'b1;
        m_bcvec = his;
      end
    end
    if (tk) begin
      m_irr[m_offvec] = 1'b0;
      m_isr[m_offvec] = 1'b1;
    end
    if (ok) begin
      m_irr[acc_vec] = 1'b1;
      if (acc_level) m_tmr[acc_vec] = 1'b1;
    end
    if (tpr_we) m_tpr = int'(tpr_wdata & 32'hFF);
    m_offv = cand && en_i && !tk && !tpr_we;
    if (hir >= 0) m_offvec = hir;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    acc_valid = 0; acc_level = 0; offer_ready = 0; eoi_we = 0; tpr_we = 0;
  endtask

  task automatic accept(input int v, input bit lvl, output bit got);
    acc_valid = 1; acc_vec = v[7:0]; acc_level = lvl;
    #1 got = acc_ok;
    tick();
    idle();
  endtask

  task automatic set_tpr(input logic [31:0] d);
    tpr_we = 1; tpr_wdata = d; tick(); idle();
  endtask

  task automatic take();
    offer_ready = 1; tick(); idle();
  endtask

  task automatic eoi();
    eoi_we = 1; tick(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    rst_n = 0; en_i = 1; acc_vec = 0; tpr_wdata = 0;
    idle();
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0;
    m_offv = 0; m_offvec = 0; m_bcv = 0; m_bcvec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(offer_valid == 0 && ppr_o == 0 && eoi_bc_valid == 0, "R9 reset state", offer_valid, 0);

    // R1: accept edge vector, offered after the next edge
    accept('h45, 0, got);
    chk(got == 1, "R1 accept ok", got, 1);
    tick();
    chk(offer_valid && offer_vec == 8'h45, "R1 offered", offer_vec, 'h45);

    // R6: reserved vectors never offered
    accept(5, 0, got);
    accept(15, 1, got);
    tick();
    chk(offer_vec == 8'h45, "R6 reserved ignored", offer_vec, 'h45);

    // R4: only low byte kept; R10 withdraw after write
    set_tpr(32'hABCD_EF50);
    chk(ppr_o == 8'h50, "R4 tpr low byte", ppr_o, 'h50);
    chk(offer_valid == 0, "R10 withdraw after tpr", offer_valid, 0);
    tick();
    chk(offer_valid == 0, "R5 blocked by ppr", offer_valid, 0);
    set_tpr(32'h0000_0040);
    tick();
    chk(offer_valid == 0, "R5 equal class blocked", offer_valid, 0);
    set_tpr(32'hFFFF_FF3F);
    tick();
    chk(offer_valid && offer_vec == 8'h45, "R5 class above ppr", offer_vec, 'h45);

    // R2: duplicate level request refused
    accept('h62, 1, got);
    chk(got == 1, "R2 first level ok", got, 1);
    accept('h62, 1, got);
    chk(got == 0, "R2 duplicate refused", got, 0);
    tick();
    chk(offer_vec == 8'h62, "R5 highest offered", offer_vec, 'h62);

    // R7 / R10 / R3
    take();
    chk(offer_valid == 0, "R10 withdraw after take", offer_valid, 0);
    chk(ppr_o == 8'h60, "R3 ppr from in-service", ppr_o, 'h60);
    tick();
    chk(offer_valid == 0, "R7 lower class held", offer_valid, 0);

    // R8: retire level vector with broadcast
    eoi();
    chk(eoi_bc_valid && eoi_bc_vec == 8'h62, "R8 broadcast", eoi_bc_vec, 'h62);
    chk(ppr_o == 8'h3F, "R8 ppr restored", ppr_o, 'h3F);
    tick();
    chk(eoi_bc_valid == 0, "R8 one-cycle pulse", eoi_bc_valid, 0);
    eoi();
    chk(eoi_bc_valid == 0, "R8 empty eoi quiet", eoi_bc_valid, 0);

    // R7: accept and take of the same vector in one cycle
    tick();
    chk(offer_valid && offer_vec == 8'h45, "R7 offer before take", offer_vec, 'h45);
    acc_valid = 1; acc_vec = 8'h45; acc_level = 0; offer_ready = 1;
    tick(); idle();
    chk(ppr_o == 8'h40, "R7 in-service set", ppr_o, 'h40);
    eoi();
    chk(eoi_bc_valid == 0, "R8 edge eoi no pulse", eoi_bc_valid, 0);
    tick();
    chk(offer_valid && offer_vec == 8'h45, "R7 pending kept", offer_vec, 'h45);

    // R9: disable
    en_i = 0;
    #1;
    chk(acc_ready == 0 && offer_valid == 0, "R9 disabled quiet", offer_valid, 0);
    accept('hA0, 0, got);
    chk(got == 0, "R9 accept blocked", got, 0);
    tick();
    en_i = 1;
    tick(); tick();
    chk(offer_valid && offer_vec == 8'h45, "R9 state kept", offer_vec, 'h45);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      en_i        = ($urandom_range(0, 19) != 0);
      acc_valid   = ($urandom_range(0, 2) == 0);
      acc_vec     = 8'($urandom_range(0, 255));
      acc_level   = $urandom_range(0, 1);
      offer_ready = ($urandom_range(0, 1) == 0);
      eoi_we      = ($urandom_range(0, 4) == 0);
      tpr_we      = ($urandom_range(0, 15) == 0);
      tpr_wdata   = $urandom & 32'hFFFF_FF7F;
      tick();
    end
    idle();
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule